// File: doc/BRIEF.md
# Vector Power License Controller

This block decides, for one processor core, which of three power licenses the core runs under while it executes wide vector instructions. Every cycle the issue stage presents a request flag, the operand width and a heavy/light class. Heavy means floating-point work, integer multiplies or leading-zero counts. Every other vector operation is light, including logic, add and shuffles. Light wide work moves the core to the middle license at once. Dense heavy work moves it to the middle or to the slowest license. Heavy work that is not yet dense is slowed down by throttling issue, without any frequency change.

Each upward license change stalls the front end for a fixed number of cycles. Density is measured over a sliding window of recent cycles. A raised license is held until a quiet period passes with no instruction that needs it. The license then drops one level at a time. A combinational frequency code is formed from the license and the number of active cores. A cycle counter for each license can be read through a select input.

Top module: `lic_power_ctl`

## Requirements
- R1: After reset the license output is 0 and every residency counter reads 0. The license is always one of 0 (fastest), 1 (middle) or 2 (slowest), and never 3.
- R2: Width code 0 means 128-bit operands and code 3 is treated the same way. Requests with either code never raise the license and never stall, whatever their heavy flag.
- R3: In the run state, a 512-bit request (width code 2) that does not meet the 512-bit density test asks for license 1. Any request that asks for a license above the current one stalls in that same cycle. The block then stays in a switch state for SWITCH_CYC cycles, with the stall held high, and the license takes the new value after the last of those cycles.
- R4: A window counts heavy 256- or 512-bit requests over the previous WIN cycles. When that count is at least THRESH, a heavy 256-bit request asks for license 1. A second window counts only heavy 512-bit requests. When that count is at least THRESH, a heavy 512-bit request asks for license 2.
- R5: A heavy 256-bit request at license 0, or a heavy 512-bit request below license 2, is throttled. It stalls except in cycles where a free-running modulo-THR_PERIOD phase counter, which starts at 0 in the first cycle after reset, reads 0.
- R6: In the run state with a raised license, a request asking for exactly the current license reloads a hold timer to HOLD_CYC. Otherwise the timer counts down by one each cycle. A cycle that finds it at 0 lowers the license by exactly one level and reloads the timer.
- R7: Light 256-bit requests (width code 1) never raise the license and never stall.
- R8: freq_code equals base(L) minus step(L) × (n − 1), with a floor of FREQ_FLOOR. Here n is the active-core count, a count of 0 counts as 1, and at license 2 n is capped at L2_CORE_CAP. The defaults are base 32/31/29 and step 1/1/2.
- R9: Each cycle adds one to the counter of the current license, and the counters saturate at all ones. res_sel 0 to 2 picks the counter shown on res_count, and select 3 shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | A vector instruction is presented for issue |
| op_width | input | 2 | Operand width code: 0=128, 1=256, 2=512, 3=treated as 128 |
| op_heavy | input | 1 | Instruction belongs to the heavy class |
| active_cores | input | CORE_W | Number of cores running code on the socket |
| res_sel | input | 2 | Residency counter select |
| lic_state | output | 2 | Current license, 0 fastest to 2 slowest |
| fe_stall | output | 1 | Front-end issue stall |
| freq_code | output | FREQ_W | Frequency code in 100 MHz units |
| res_count | output | CNT_W | Selected residency counter |

## Verification
The bench drives heavy 256-bit work every cycle from license 0. This exposes a design that raises the license before the window reaches its threshold, or one that stalls throttled issues in the wrong phase. The heavy 512-bit sequence has to pass first through the immediate switch to license 1 and then through throttling before it reaches license 2. A design that skips the middle license, or that refreshes the hold on the wrong license, gets the step-down timing wrong. The active-core count sweeps above 9 at license 2, which catches a frequency map that keeps lowering the code past the cap. A long idle stretch drives a residency counter into saturation, which catches a design whose counter wraps.

// File: rtl/lic_pkg.sv
`timescale 1ns/1ps
package lic_pkg;
  typedef enum logic [1:0] {
    LIC_FAST = 2'd0,
    LIC_MID  = 2'd1,
    LIC_SLOW = 2'd2
  } lic_e;

  typedef enum logic [1:0] {
    OPW_128 = 2'd0,
    OPW_256 = 2'd1,
    OPW_512 = 2'd2,
    OPW_RSV = 2'd3
  } opw_e;

  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_SWITCH = 1'b1
  } ctl_st_e;

  localparam int NUM_LIC = 3;
endpackage

// File: rtl/lic_density_win.sv
`timescale 1ns/1ps
module lic_density_win #(
  parameter int WIN    = 64,
  parameter int THRESH = 56
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  output logic sustained
);
  localparam int CW = $clog2(WIN + 1);

  logic [WIN-1:0] hist_q, hist_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    hist_d = {hist_q[WIN-2:0], sample};
    cnt_d  = cnt_q + CW'(sample) - CW'(hist_q[WIN-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else begin
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sustained = (cnt_q >= CW'(THRESH));
endmodule

// File: rtl/lic_freq_map.sv
`timescale 1ns/1ps
module lic_freq_map #(
  parameter int CORE_W      = 5,
  parameter int FREQ_W      = 8,
  parameter int F_BASE0     = 32,
  parameter int F_BASE1     = 31,
  parameter int F_BASE2     = 29,
  parameter int F_STEP0     = 1,
  parameter int F_STEP1     = 1,
  parameter int F_STEP2     = 2,
  parameter int L2_CORE_CAP = 9,
  parameter int FREQ_FLOOR  = 8
) (
  input  logic [1:0]        lic,
  input  logic [CORE_W-1:0] active_cores,
  output logic [FREQ_W-1:0] freq_code
);
  localparam int AW = FREQ_W + CORE_W + 1;

  logic [AW-1:0] eff, base, step, red;

  always_comb begin
    eff = AW'(active_cores);
    if (eff == '0) eff = AW'(1);
    if (lic == 2'd2 && eff > AW'(L2_CORE_CAP)) eff = AW'(L2_CORE_CAP);
    case (lic)
      2'd1:    begin base = AW'(F_BASE1); step = AW'(F_STEP1); end
      2'd2:    begin base = AW'(F_BASE2); step = AW'(F_STEP2); end
      default: begin base = AW'(F_BASE0); step = AW'(F_STEP0); end
    endcase
    red = step * (eff - AW'(1));
    if (base < red + AW'(FREQ_FLOOR)) freq_code = FREQ_W'(FREQ_FLOOR);
    else                              freq_code = FREQ_W'(base - red);
  end
endmodule

// File: rtl/lic_residency.sv
`timescale 1ns/1ps
module lic_residency
  import lic_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       lic,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_val
);
  logic [NUM_LIC*CNT_W-1:0] all_cnt;

  for (genvar g = 0; g < NUM_LIC; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_en;

    always_comb begin
      cnt_en = (lic == 2'(g)) && !(&cnt_q);
      cnt_d  = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign all_cnt[g*CNT_W +: CNT_W] = cnt_q;
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_LIC; k++) begin
      if (rd_sel == 2'(k)) rd_val = all_cnt[k*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/lic_power_ctl.sv
`timescale 1ns/1ps
module lic_power_ctl
  import lic_pkg::*;
#(
  parameter int WIN         = 64,
  parameter int THRESH      = 56,
  parameter int HOLD_CYC    = 4000000,
  parameter int SWITCH_CYC  = 16,
  parameter int THR_PERIOD  = 4,
  parameter int CNT_W       = 40,
  parameter int CORE_W      = 5,
  parameter int FREQ_W      = 8,
  parameter int F_BASE0     = 32,
  parameter int F_BASE1     = 31,
  parameter int F_BASE2     = 29,
  parameter int F_STEP0     = 1,
  parameter int F_STEP1     = 1,
  parameter int F_STEP2     = 2,
  parameter int L2_CORE_CAP = 9,
  parameter int FREQ_FLOOR  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_vld,
  input  logic [1:0]        op_width,
  input  logic              op_heavy,
  input  logic [CORE_W-1:0] active_cores,
  input  logic [1:0]        res_sel,
  output logic [1:0]        lic_state,
  output logic              fe_stall,
  output logic [FREQ_W-1:0] freq_code,
  output logic [CNT_W-1:0]  res_count
);
  localparam int HW  = $clog2(HOLD_CYC + 1);
  localparam int SWW = $clog2(SWITCH_CYC + 1);
  localparam int PW  = $clog2(THR_PERIOD);

  lic_e          lic_q, lic_d, tgt_q, tgt_d, need;
  ctl_st_e       st_q, st_d;
  logic [HW-1:0] hold_q, hold_d;
  logic [SWW-1:0] sw_q, sw_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [1:0]    smp, sus;
  logic          raise, refresh, thr_req, thr_stall, in_switch;

  // density windows: index 0 counts heavy 256/512, index 1 heavy 512 only
  always_comb begin
    smp[0] = op_vld && op_heavy &&
             (op_width == OPW_256 || op_width == OPW_512);
    smp[1] = op_vld && op_heavy && (op_width == OPW_512);
  end

  for (genvar k = 0; k < 2; k++) begin : g_win
    lic_density_win #(.WIN(WIN), .THRESH(THRESH)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (smp[k]),
      .sustained (sus[k])
    );
  end

  // license asked for by the request of this cycle
  always_comb begin
    need = LIC_FAST;
    if (op_vld) begin
      case (op_width)
        OPW_256: if (op_heavy && sus[0]) need = LIC_MID;
        OPW_512: need = (op_heavy && sus[1]) ? LIC_SLOW : LIC_MID;
        default: need = LIC_FAST;
      endcase
    end
  end

  always_comb begin
    in_switch = (st_q == ST_SWITCH);
    raise     = !in_switch && (need > lic_q);
    refresh   = !in_switch && !raise && (lic_q != LIC_FAST) && (need == lic_q);
    thr_req   = op_vld && op_heavy &&
                ((op_width == OPW_256 && lic_q == LIC_FAST) ||
                 (op_width == OPW_512 && lic_q != LIC_SLOW));
    thr_stall = thr_req && (ph_q != '0);
    fe_stall  = in_switch || raise || thr_stall;
    ph_d      = (ph_q == PW'(THR_PERIOD - 1)) ? '0 : ph_q + PW'(1);
  end

  // next-state logic
  always_comb begin
    st_d   = st_q;
    lic_d  = lic_q;
    tgt_d  = tgt_q;
    hold_d = hold_q;
    sw_d   = sw_q;
    case (st_q)
      ST_RUN: begin
        if (raise) begin
          st_d  = ST_SWITCH;
          tgt_d = need;
          sw_d  = SWW'(SWITCH_CYC);
        end else if (refresh) begin
          hold_d = HW'(HOLD_CYC);
        end else if (lic_q != LIC_FAST) begin
          if (hold_q == '0) begin
            lic_d  = lic_e'(lic_q - 2'd1);
            hold_d = HW'(HOLD_CYC);
          end else begin
            hold_d = hold_q - HW'(1);
          end
        end
      end
      default: begin
        if (sw_q <= SWW'(1)) begin
          st_d   = ST_RUN;
          lic_d  = tgt_q;
          hold_d = HW'(HOLD_CYC);
        end else begin
          sw_d = sw_q - SWW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      lic_q  <= LIC_FAST;
      tgt_q  <= LIC_FAST;
      hold_q <= '0;
      sw_q   <= '0;
      ph_q   <= '0;
    end else begin
      st_q   <= st_d;
      lic_q  <= lic_d;
      tgt_q  <= tgt_d;
      hold_q <= hold_d;
      sw_q   <= sw_d;
      ph_q   <= ph_d;
    end
  end

  assign lic_state = lic_q;

  lic_freq_map #(
    .CORE_W(CORE_W), .FREQ_W(FREQ_W),
    .F_BASE0(F_BASE0), .F_BASE1(F_BASE1), .F_BASE2(F_BASE2),
    .F_STEP0(F_STEP0), .F_STEP1(F_STEP1), .F_STEP2(F_STEP2),
    .L2_CORE_CAP(L2_CORE_CAP), .FREQ_FLOOR(FREQ_FLOOR)
  ) u_freq (
    .lic          (lic_q),
    .active_cores (active_cores),
    .freq_code    (freq_code)
  );

  lic_residency #(.CNT_W(CNT_W)) u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .lic    (lic_q),
    .rd_sel (res_sel),
    .rd_val (res_count)
  );
endmodule

// File: rtl/lic_power_ctl_chk.sv
`timescale 1ns/1ps
module lic_power_ctl_chk #(
  parameter int FREQ_W     = 8,
  parameter int FREQ_FLOOR = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        lic_state,
  input logic              fe_stall,
  input logic              in_switch,
  input logic              op_vld,
  input logic [1:0]        op_width,
  input logic [FREQ_W-1:0] freq_code
);
  p_lic_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lic_state != 2'd3);

  p_narrow_no_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && (op_width == 2'd0 || op_width == 2'd3) && !in_switch)
      |=> (lic_state <= $past(lic_state)));

  p_switch_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_switch |-> fe_stall);

  p_raise_after_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lic_state > $past(lic_state)) |-> ($past(in_switch) && $past(fe_stall)));

  p_step_down_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lic_state < $past(lic_state)) |-> (lic_state == $past(lic_state) - 2'd1));

  p_freq_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    freq_code >= FREQ_W'(FREQ_FLOOR));
endmodule

bind lic_power_ctl lic_power_ctl_chk #(
  .FREQ_W(FREQ_W), .FREQ_FLOOR(FREQ_FLOOR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lic_state (lic_state),
  .fe_stall  (fe_stall),
  .in_switch (in_switch),
  .op_vld    (op_vld),
  .op_width  (op_width),
  .freq_code (freq_code)
);

// File: tb/lic_power_ctl_tb.sv
`timescale 1ns/1ps
module lic_power_ctl_tb_top;
  localparam int WIN = 16, TH = 12, HOLD = 40, SW = 6, PER = 4;
  localparam int CNTW = 10, CW = 5, FW = 8;

  logic clk, rst_n, op_vld, op_heavy;
  logic [1:0] op_width, res_sel, lic_state;
  logic [CW-1:0] active_cores;
  logic fe_stall;
  logic [FW-1:0] freq_code;
  logic [CNTW-1:0] res_count;

  lic_power_ctl #(
    .WIN(WIN), .THRESH(TH), .HOLD_CYC(HOLD), .SWITCH_CYC(SW),
    .THR_PERIOD(PER), .CNT_W(CNTW), .CORE_W(CW), .FREQ_W(FW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_width(op_width),
    .op_heavy(op_heavy), .active_cores(active_cores), .res_sel(res_sel),
    .lic_state(lic_state), .fe_stall(fe_stall), .freq_code(freq_code),
    .res_count(res_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_lic, m_st, m_tgt, m_sw, m_hold, m_ph;
  int m_res[3];
  bit q_w[$];
  bit q_5[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int fexp(int l, int c);
    int e, b, s, r;
    e = (c == 0) ? 1 : c;
    if (l == 2 && e > 9) e = 9;
    b = (l == 1) ? 31 : (l == 2) ? 29 : 32;
    s = (l == 2) ? 2 : 1;
    r = b - s * (e - 1);
    return (r < 8) ? 8 : r;
  endfunction

  function automatic int ones(bit q[$]);
    int n = 0;
    foreach (q[i]) n += q[i];
    return n;
  endfunction

  task automatic step(bit v, int w, bit h);
    int cores, sel, need, exp_stall, sat;
    bit sus_w, sus_5, raise, thr;
    cores = (cyc * 7) % 24;
    sel = cyc % 4;
    op_vld = v; op_width = 2'(w); op_heavy = h;
    active_cores = CW'(cores); res_sel = 2'(sel);
    #1;
    sus_w = ones(q_w) >= TH;
    sus_5 = ones(q_5) >= TH;
    need = 0;
    if (v && w == 1 && h && sus_w) need = 1;
    if (v && w == 2) need = (h && sus_5) ? 2 : 1;
    raise = (m_st == 0) && (need > m_lic);
    thr = v && h && ((w == 1 && m_lic == 0) || (w == 2 && m_lic != 2)) && (m_ph != 0);
    exp_stall = (m_st == 1) || raise || thr;
    chk(cur_req, "license", lic_state, m_lic);
    chk(cur_req, "stall", fe_stall, exp_stall);
    chk("R8", "freq_code", freq_code, fexp(m_lic, cores));
    chk("R9", "res_count", res_count, (sel < 3) ? m_res[sel] : 0);
    // advance the reference one clock
    sat = (1 << CNTW) - 1;
    if (m_res[m_lic] < sat) m_res[m_lic]++;
    q_w.push_back(v && h && (w == 1 || w == 2));
    q_5.push_back(v && h && w == 2);
    if (q_w.size() > WIN) void'(q_w.pop_front());
    if (q_5.size() > WIN) void'(q_5.pop_front());
    m_ph = (m_ph + 1) % PER;
    if (m_st == 1) begin
      if (m_sw <= 1) begin m_st = 0; m_lic = m_tgt; m_hold = HOLD; end
      else m_sw--;
    end else if (raise) begin
      m_st = 1; m_tgt = need; m_sw = SW;
    end else if (m_lic != 0 && need == m_lic) begin
      m_hold = HOLD;
    end else if (m_lic != 0) begin
      if (m_hold == 0) begin m_lic--; m_hold = HOLD; end
      else m_hold--;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(int n, bit v, int w, bit h);
    for (int i = 0; i < n; i++) step(v, w, h);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_lic = 0; m_st = 0; m_tgt = 0; m_sw = 0; m_hold = 0; m_ph = 0;
    for (int i = 0; i < 3; i++) m_res[i] = 0;
    rst_n = 1'b0; op_vld = 0; op_width = 0; op_heavy = 0;
    active_cores = 1; res_sel = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 3; s++) begin
      res_sel = 2'(s); #1;
      chk("R1", "res_count in reset", res_count, 0);
    end
    chk("R1", "license in reset", lic_state, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; run(5, 0, 0, 0);
    // R2 narrow and reserved widths
    cur_req = "R2";
    for (int i = 0; i < 40; i++) step(1, (i % 2) ? 0 : 3, (i % 3) == 0);
    // R7 light 256
    cur_req = "R7"; run(40, 1, 1, 0);
    // R5 heavy 256 throttled before density reached, then R4 raise to 1
    cur_req = "R5"; run(12, 1, 1, 1);
    cur_req = "R4"; run(30, 1, 1, 1);
    // R6 quiet hold then step down
    cur_req = "R6"; run(100, 0, 0, 0);
    // R3 single light 512, then another inside the hold period
    cur_req = "R3"; step(1, 2, 0); run(20, 0, 0, 0);
    step(1, 2, 0); run(60, 0, 0, 0);
    // R4 heavy 512: immediate license 1, throttling, then license 2
    cur_req = "R4"; run(60, 1, 2, 1);
    cur_req = "R6"; run(120, 0, 0, 0);
    // R9 long idle drives the license 0 counter into saturation
    cur_req = "R9"; run(1100, 0, 0, 0);
    chk("R9", "saturated license 0 count", m_res[0], (1 << CNTW) - 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule